// File: doc/BRIEF.md
# Rate-Adjustable PTP Time Counter

This block keeps a 64-bit nanosecond time of day on top of a free-running raw cycle count. The count advances once every 8 ns, which is a fixed 125 MHz reference. The block does not count nanoseconds directly. It holds three values: a nanosecond base, the cycle count at which that base was taken, and a rate multiplier. The current time is the base plus the cycles elapsed since the reference, multiplied by the multiplier and shifted right by 28 bits. The nominal multiplier is 2^31, which gives exactly 8 ns per cycle.

A single command port carries four operations:
- **Set** loads a new time.
- **Adjust** shifts the time by a signed nanosecond offset.
- **Read** returns a snapshot of the time.
- **Rate** changes the frequency from a signed scaled-ppm word, which is parts per million with 16 fractional bits.

Before a read or a rate change, the time elapsed so far is folded into the base at the current rate. As a result, a later rate change never rescales time that has already passed. A host or a servo drives the command port. The time output can be used directly to stamp events.

Top module: `ptp_rate_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `time_ns` is 0, `rd_valid` is 0 and `rate_mult` is 2^31 (0x8000_0000).
- R2: Without commands, `time_ns` registered at a clock edge equals base + ((cyc_cnt − ref) × rate_mult) >> 28, computed at full product width and truncated to 64 bits, where `cyc_cnt` is the value sampled at that edge. At the nominal multiplier this is 8 ns per raw cycle.
- R3: A command with `cmd_op` = 0 (set) makes the base equal to `cmd_data` and makes the reference the sampled `cyc_cnt`. `time_ns` at that edge equals `cmd_data`.
- R4: `cmd_op` = 1 (adjust) adds `cmd_data`, read as signed two's complement, to the time. It changes neither the reference nor `rate_mult`.
- R5: `cmd_op` = 2 (read) drives `rd_valid` high for exactly the following cycle, with `rd_ns` equal to the time at the command edge. `rd_valid` is high at no other time.
- R6: `cmd_op` = 3 (rate) sets `rate_mult` = 2^31 + trunc(p × 512 / 15625). Here p is `cmd_data` read as signed scaled ppm, and the division truncates toward zero.
- R7: For the rate command, p is first clamped to ±2,097,152,000, which corresponds to ±32,000,000 ppb. `rate_mult` therefore stays within 2^31 ± 68,719,476.
- R8: Both the read and the rate command fold the time elapsed up to the command edge into the base at the old multiplier, and re-capture the reference at that edge.
- R9: While `cmd_valid` is low, `cmd_op` and `cmd_data` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cyc_cnt | input | 64 | free-running raw cycle count (8 ns per count) |
| cmd_valid | input | 1 | command strobe, one command per cycle |
| cmd_op | input | 2 | 0 set, 1 adjust, 2 read, 3 rate |
| cmd_data | input | 64 | time, signed offset, or signed scaled ppm |
| time_ns | output | 64 | current time in nanoseconds |
| rd_valid | output | 1 | read snapshot valid |
| rd_ns | output | 64 | read snapshot |
| rate_mult | output | 32 | active rate multiplier |

## Verification
The time is tracked across irregular cycle-count steps between 1 and 300 per clock. Irregular steps separate a correct elapsed-times-multiplier scaling from a design that simply adds 8 per clock.

Directed rate commands probe four cases:
- small negative values (−1 and −31), which expose truncation toward zero;
- the exact clamp limits;
- values beyond the limits in both directions, which tell saturation apart from wrapping;
- long idle stretches after a rate change, which reveal whether elapsed time was folded at the old rate or rescaled at the new one.

Random mixes of all four commands, plus strobes with `cmd_valid` low, then compare every cycle against an independent arithmetic model.

// File: rtl/ptp_rt_pkg.sv
package ptp_rt_pkg;
    localparam int TW = 64;
    localparam int MW = 32;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_ADJ  = 2'd1,
        OP_READ = 2'd2,
        OP_RATE = 2'd3
    } rt_op_e;

    typedef struct packed {
        logic [TW-1:0] base;
        logic [TW-1:0] ref_cyc;
        logic [MW-1:0] mult;
        logic [TW-1:0] time_ns;
        logic          rd_valid;
        logic [TW-1:0] rd_ns;
    } rt_state_t;
endpackage

// File: rtl/ptp_elapsed_scale.sv
module ptp_elapsed_scale #(
    parameter int TW    = 64,
    parameter int MW    = 32,
    parameter int SHIFT = 28
) (
    input  logic [TW-1:0] elapsed,
    input  logic [MW-1:0] mult,
    output logic [TW-1:0] ns
);
    localparam int PW = TW + MW;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(elapsed) * PW'(mult);
        ns   = TW'(prod >> SHIFT);
    end
endmodule

// File: rtl/ptp_rate_conv.sv
module ptp_rate_conv #(
    parameter int          TW        = 64,
    parameter int          MW        = 32,
    parameter int          SHIFT     = 28,
    parameter int          NS_PER_CY = 8,
    parameter longint      PPM_LIMIT = 64'sd2097152000,
    parameter int          MUL_NUM   = 512,
    parameter int          MUL_DEN   = 15625
) (
    input  logic [TW-1:0] sppm_raw,
    output logic [MW-1:0] mult
);
    localparam logic [MW-1:0] NOMINAL = MW'(NS_PER_CY) << SHIFT;

    logic signed [TW-1:0] sppm;
    logic signed [TW-1:0] clamped;
    logic signed [TW-1:0] scaled;
    logic signed [TW-1:0] delta;

    always_comb begin
        sppm = signed'(sppm_raw);
        if (sppm > TW'(PPM_LIMIT))
            clamped = TW'(PPM_LIMIT);
        else if (sppm < -TW'(PPM_LIMIT))
            clamped = -TW'(PPM_LIMIT);
        else
            clamped = sppm;
        scaled = clamped * TW'(MUL_NUM);
        delta  = scaled / TW'(MUL_DEN);
        mult   = NOMINAL + MW'(delta);
    end
endmodule

// File: rtl/ptp_rate_timer.sv
module ptp_rate_timer
    import ptp_rt_pkg::*;
#(
    parameter int     SHIFT     = 28,
    parameter int     NS_PER_CY = 8,
    parameter longint PPM_LIMIT = 64'sd2097152000,
    parameter int     MUL_NUM   = 512,
    parameter int     MUL_DEN   = 15625,
    parameter int     MAX_DELTA = 68719476
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [63:0]   cyc_cnt,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [63:0]   cmd_data,
    output logic [63:0]   time_ns,
    output logic          rd_valid,
    output logic [63:0]   rd_ns,
    output logic [31:0]   rate_mult
);
    localparam logic [MW-1:0] NOMINAL = MW'(NS_PER_CY) << SHIFT;

    rt_state_t st_q, st_d;
    rt_op_e    op;

    logic [TW-1:0] now_ns;
    logic [TW-1:0] next_scaled;
    logic [MW-1:0] new_mult;

    assign op = rt_op_e'(cmd_op);

    ptp_elapsed_scale #(.TW(TW), .MW(MW), .SHIFT(SHIFT)) u_now (
        .elapsed (cyc_cnt - st_q.ref_cyc),
        .mult    (st_q.mult),
        .ns      (now_ns)
    );

    ptp_elapsed_scale #(.TW(TW), .MW(MW), .SHIFT(SHIFT)) u_next (
        .elapsed (cyc_cnt - st_d.ref_cyc),
        .mult    (st_d.mult),
        .ns      (next_scaled)
    );

    ptp_rate_conv #(
        .TW(TW), .MW(MW), .SHIFT(SHIFT), .NS_PER_CY(NS_PER_CY),
        .PPM_LIMIT(PPM_LIMIT), .MUL_NUM(MUL_NUM), .MUL_DEN(MUL_DEN)
    ) u_conv (
        .sppm_raw (cmd_data),
        .mult     (new_mult)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_SET: begin
                    st_d.base    = cmd_data;
                    st_d.ref_cyc = cyc_cnt;
                end
                OP_ADJ: begin
                    st_d.base = st_q.base + cmd_data;
                end
                OP_READ: begin
                    st_d.base     = st_q.base + now_ns;
                    st_d.ref_cyc  = cyc_cnt;
                    st_d.rd_valid = 1'b1;
                    st_d.rd_ns    = st_q.base + now_ns;
                end
                OP_RATE: begin
                    st_d.base    = st_q.base + now_ns;
                    st_d.ref_cyc = cyc_cnt;
                    st_d.mult    = new_mult;
                end
                default: ;
            endcase
        end
        st_d.time_ns = st_d.base + next_scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base     <= '0;
            st_q.ref_cyc  <= '0;
            st_q.mult     <= NOMINAL;
            st_q.time_ns  <= '0;
            st_q.rd_valid <= 1'b0;
            st_q.rd_ns    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_ns   = st_q.time_ns;
    assign rd_valid  = st_q.rd_valid;
    assign rd_ns     = st_q.rd_ns;
    assign rate_mult = st_q.mult;

    assert_mult_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mult >= NOMINAL - MW'(MAX_DELTA)) && (st_q.mult <= NOMINAL + MW'(MAX_DELTA)))
        else $error("rate multiplier outside clamp window");

    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> rd_valid)
        else $error("read did not pulse rd_valid");

    assert_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && cmd_op == 2'd2)) |=> !rd_valid)
        else $error("rd_valid without read");

    assert_rate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && cmd_op == 2'd3)) |=> $stable(rate_mult))
        else $error("multiplier changed without rate command");

    assert_set_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> (time_ns == $past(cmd_data)))
        else $error("set did not load time");
endmodule

// File: tb/ptp_rate_timer_test.sv
module ptp_rate_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cyc_cnt;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [63:0] cmd_data;
    logic [63:0] time_ns;
    logic        rd_valid;
    logic [63:0] rd_ns;
    logic [31:0] rate_mult;

    int total = 0;
    int bad   = 0;

    localparam longint LIM = 64'sd2097152000;
    localparam logic [31:0] NOM = 32'h8000_0000;

    logic [63:0] m_base, m_ref, m_rd;
    logic [31:0] m_mult;
    logic        m_rv;

    always #2 clk = ~clk;

    ptp_rate_timer uut (
        .clk(clk), .rst_n(rst_n), .cyc_cnt(cyc_cnt), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .time_ns(time_ns),
        .rd_valid(rd_valid), .rd_ns(rd_ns), .rate_mult(rate_mult)
    );

    function automatic logic [63:0] scale(logic [63:0] el, logic [31:0] m);
        logic [127:0] p;
        p = {64'd0, el} * {96'd0, m};
        return p[91:28];
    endfunction

    function automatic logic [31:0] rate_of(logic [63:0] raw);
        longint p, d;
        p = longint'(raw);
        if (p > LIM) p = LIM;
        if (p < -LIM) p = -LIM;
        d = (p * 512) / 15625;
        return NOM + 32'(d);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at negedge; applies one command and checks after the edge
    task automatic step(logic v, logic [1:0] op, logic [63:0] d, int adv, string req);
        logic [63:0] now;
        cmd_valid = v;
        cmd_op    = op;
        cmd_data  = d;
        cyc_cnt   = cyc_cnt + 64'(adv);
        @(posedge clk);
        #1;
        now  = m_base + scale(cyc_cnt - m_ref, m_mult);
        m_rv = 1'b0;
        if (v) begin
            case (op)
                2'd0: begin m_base = d; m_ref = cyc_cnt; end
                2'd1: m_base = m_base + d;
                2'd2: begin m_base = now; m_ref = cyc_cnt; m_rv = 1'b1; m_rd = now; end
                default: begin m_base = now; m_ref = cyc_cnt; m_mult = rate_of(d); end
            endcase
        end
        check({req, " time"}, time_ns, m_base + scale(cyc_cnt - m_ref, m_mult));
        check({req, " rd_valid R5"}, {63'd0, rd_valid}, {63'd0, m_rv});
        if (m_rv) check({req, " rd_ns R5"}, rd_ns, m_rd);
        check({req, " mult"}, {32'd0, rate_mult}, {32'd0, m_mult});
        @(negedge clk);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        rst_n = 1'b0; cyc_cnt = 64'd5000; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = '0;
        repeat (3) @(negedge clk);
        check("R1 time", time_ns, 64'd0);
        check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R1 mult", {32'd0, rate_mult}, {32'd0, NOM});
        rst_n = 1'b1;
        m_base = 0; m_ref = 0; m_mult = NOM; m_rv = 0; m_rd = 0;
        // R2 nominal: 8 ns per cycle
        step(1'b0, 2'd0, 64'd0, 1, "R2");
        step(1'b0, 2'd0, 64'd0, 10, "R2");
        check("R2 nominal 8ns", time_ns, 64'd8 * cyc_cnt);
        // R3 set
        step(1'b1, 2'd0, 64'd1_000_000_000, 3, "R3");
        check("R3 set value", time_ns, 64'd1_000_000_000);
        step(1'b0, 2'd0, 64'd0, 7, "R3");
        check("R3 after set", time_ns, 64'd1_000_000_056);
        // R4 adjust positive and negative
        step(1'b1, 2'd1, 64'd500, 0, "R4");
        step(1'b1, 2'd1, -64'sd2000, 2, "R4");
        // R5 read
        step(1'b1, 2'd2, 64'd0, 4, "R5");
        step(1'b0, 2'd2, 64'd0, 4, "R5 R9");
        // R6 small negative truncation toward zero
        step(1'b1, 2'd3, -64'sd1, 1, "R6");
        check("R6 -1 truncates", {32'd0, rate_mult}, {32'd0, NOM});
        step(1'b1, 2'd3, -64'sd31, 1, "R6");
        check("R6 -31", {32'd0, rate_mult}, {32'd0, NOM - 32'd1});
        // R7 limits and saturation
        step(1'b1, 2'd3, 64'(LIM), 1, "R7");
        check("R7 +limit", {32'd0, rate_mult}, {32'd0, NOM + 32'd68719476});
        step(1'b1, 2'd3, 64'sd9_000_000_000, 1, "R7");
        check("R7 +sat", {32'd0, rate_mult}, {32'd0, NOM + 32'd68719476});
        step(1'b1, 2'd3, -64'sd9_000_000_000, 1, "R7");
        check("R7 -sat", {32'd0, rate_mult}, {32'd0, NOM - 32'd68719476});
        // R8 fold: long run at slow rate, then switch to fast
        for (int i = 0; i < 20; i++) step(1'b0, 2'd0, 64'd0, 250, "R8");
        step(1'b1, 2'd3, 64'(LIM), 100, "R8");
        for (int i = 0; i < 20; i++) step(1'b0, 2'd0, 64'd0, 250, "R8");
        // R9 strobes ignored with random garbage
        for (int i = 0; i < 10; i++)
            step(1'b0, 2'($urandom), {$urandom, $urandom}, 3, "R9");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [63:0] d;
            k = $urandom_range(0, 5);
            case (k)
                0: d = {$urandom, $urandom};
                1: d = 64'(signed'($urandom));
                3: d = 64'(longint'(signed'($urandom)) * 2);
                default: d = {$urandom, $urandom};
            endcase
            step(k < 4, 2'(k), d, $urandom_range(1, 300), "R2 R8 mix");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule